// File: doc/BRIEF.md
# Program-Counter Write Classifier

This block looks at one decoded instruction of a 32-bit register-machine instruction stream and reports whether that instruction may overwrite the program counter. The program counter is register 15. A fetch or translation front end uses the result to close a basic block, or to arm a flush, before any later instruction is fetched along a path that may be wrong.

Besides explicit branches, the block flags every other way an instruction can write register 15:

- an ALU result written to register 15;
- a single or paired load that lands in register 15;
- a multi-register load whose list contains register 15;
- an address writeback into base register 15, whether by a single access or a multi-register access.

The classifier is purely combinational. It receives the instruction class and its register fields, and returns a flag together with an "unsupported class" indication.

Top module: `pcw_classifier`

## Requirements
- R1: Class code 0 (ALU) raises `may_write_pc_o` exactly when `alu_dst_i` equals 15. The fields `mem_tgt_i`, `reg_list_i` and `mem_load_i` have no effect on this class.
- R2: For class code 1 (single load/store) with `mem_dual_i`=0, a load (`mem_load_i`=1) whose `mem_tgt_i` is 15 raises the flag. A store (`mem_load_i`=0) with `mem_tgt_i` 15 and no base hit does not raise it.
- R3: For class code 1 with `mem_dual_i`=1 and `mem_load_i`=1, the pair written is `mem_tgt_i` and `mem_tgt_i`+1. A target of 14 or 15 raises the flag; a target of 13 with no base hit does not.
- R4: Class code 2 (multi-register) with `mem_load_i`=1 and bit 15 of `reg_list_i` set raises the flag. A multi-register store with bit 15 set and no base hit does not.
- R5: Class code 1 with `mem_wb_i`=1 and `mem_base_i`=15 raises the flag, for loads and for stores. With `mem_wb_i`=0 a base of 15 alone does not raise it.
- R6: For class code 2, writeback counts as active exactly when `mult_adj_i` is nonzero. With `mem_base_i`=15, a nonzero adjustment (positive or negative) raises the flag and zero does not.
- R7: Class codes 3 (branch immediate) and 4 (branch register) always raise the flag, whatever the other fields hold.
- R8: Class codes 5, 6 and 7 force `may_write_pc_o` to 0 and raise `unsup_o`. Codes 0 to 4 keep `unsup_o` at 0.
- R9: Both outputs are a pure function of the present inputs and are valid in the same cycle the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cls_i | input | 3 | Instruction class code (0 ALU, 1 single memory, 2 multi-register, 3 branch immediate, 4 branch register) |
| alu_dst_i | input | 4 | ALU destination register number |
| mem_tgt_i | input | 4 | Single-access target register (first of the pair for dual loads) |
| mem_base_i | input | 4 | Base address register of a memory access |
| mem_load_i | input | 1 | 1 = load, 0 = store |
| mem_dual_i | input | 1 | Single access moves a register pair |
| mem_wb_i | input | 1 | Single access writes the updated address back to its base |
| reg_list_i | input | 16 | Register list of a multi-register access, bit n = register n |
| mult_adj_i | input | 8 | Signed base adjustment applied after a multi-register access |
| may_write_pc_o | output | 1 | Instruction may change the program counter |
| unsup_o | output | 1 | Class code not recognised |

## Verification
Both results are due in the very cycle their inputs are applied; no register lies on any path. The bench therefore drives a new vector just after a rising edge and compares both outputs at the following falling edge, half a period later. It compares against a behavioural model on every cycle. The stimulus is a directed sweep of each flagged and unflagged corner, followed by a long run of random vectors biased toward registers 14 and 15 and toward a zero adjustment.

// File: rtl/pcw_pkg.sv
package pcw_pkg;
  localparam int unsigned CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU   = 3'd0,
    CLS_MEM   = 3'd1,
    CLS_MULT  = 3'd2,
    CLS_BIMM  = 3'd3,
    CLS_BREG  = 3'd4
  } insn_cls_e;
endpackage

// File: rtl/pcw_alu_chk.sv
module pcw_alu_chk #(
  parameter int unsigned REG_W = 4
) (
  input  logic [REG_W-1:0] dst_i,
  output logic             hit_o
);
  localparam logic [REG_W-1:0] PcIdx = {REG_W{1'b1}};

  always_comb begin
    hit_o = (dst_i == PcIdx);
    // R1: any destination below the top register never hits
    p_low_dst_r1: assert (!(dst_i < PcIdx) || !hit_o);
  end
endmodule

// File: rtl/pcw_mem_chk.sv
module pcw_mem_chk #(
  parameter int unsigned REG_W = 4
) (
  input  logic [REG_W-1:0] tgt_i,
  input  logic [REG_W-1:0] base_i,
  input  logic             load_i,
  input  logic             dual_i,
  input  logic             wb_i,
  output logic             hit_o
);
  localparam logic [REG_W-1:0] PcIdx   = {REG_W{1'b1}};
  localparam logic [REG_W-1:0] PcPrev  = PcIdx - 1'b1;

  logic tgt_hit;
  logic pair_hit;
  logic base_hit;

  always_comb begin
    pair_hit = dual_i && (tgt_i == PcPrev);
    tgt_hit  = load_i && ((tgt_i == PcIdx) || pair_hit);
    base_hit = wb_i && (base_i == PcIdx);
    hit_o    = tgt_hit || base_hit;
    // R2: a store without writeback never hits
    p_store_quiet_r2: assert (load_i || wb_i || !hit_o);
    // R5: without writeback, a hit needs a load
    p_base_needs_wb_r5: assert (wb_i || load_i || !hit_o);
    // R3: dual load to the register just below the top hits
    p_pair_r3: assert (!(load_i && dual_i && tgt_i == PcPrev) || hit_o);
  end
endmodule

// File: rtl/pcw_mult_chk.sv
module pcw_mult_chk #(
  parameter int unsigned REG_W = 4,
  parameter int unsigned ADJ_W = 8
) (
  input  logic [(1<<REG_W)-1:0] list_i,
  input  logic [REG_W-1:0]      base_i,
  input  logic                  load_i,
  input  logic [ADJ_W-1:0]      adj_i,
  output logic                  hit_o
);
  localparam int unsigned        LIST_W = 1 << REG_W;
  localparam logic [REG_W-1:0]   PcIdx  = {REG_W{1'b1}};

  logic wb_on;
  logic list_hit;

  always_comb begin
    wb_on    = |adj_i;
    list_hit = load_i && list_i[LIST_W-1];
    hit_o    = list_hit || (wb_on && (base_i == PcIdx));
    // R6: zero adjustment with an empty top list bit never hits
    p_zero_adj_r6: assert (wb_on || list_i[LIST_W-1] || !hit_o);
    // R4: a store never hits through its list alone
    p_store_list_r4: assert (load_i || wb_on || !hit_o);
  end
endmodule

// File: rtl/pcw_classifier.sv
module pcw_classifier
  import pcw_pkg::*;
#(
  parameter int unsigned REG_W = 4,
  parameter int unsigned ADJ_W = 8
) (
  input  logic [CLS_W-1:0]        cls_i,
  input  logic [REG_W-1:0]        alu_dst_i,
  input  logic [REG_W-1:0]        mem_tgt_i,
  input  logic [REG_W-1:0]        mem_base_i,
  input  logic                    mem_load_i,
  input  logic                    mem_dual_i,
  input  logic                    mem_wb_i,
  input  logic [(1<<REG_W)-1:0]   reg_list_i,
  input  logic [ADJ_W-1:0]        mult_adj_i,
  output logic                    may_write_pc_o,
  output logic                    unsup_o
);
  logic alu_hit;
  logic mem_hit;
  logic mult_hit;

  pcw_alu_chk #(.REG_W(REG_W)) alu_chk_i (
    .dst_i (alu_dst_i),
    .hit_o (alu_hit)
  );

  pcw_mem_chk #(.REG_W(REG_W)) mem_chk_i (
    .tgt_i  (mem_tgt_i),
    .base_i (mem_base_i),
    .load_i (mem_load_i),
    .dual_i (mem_dual_i),
    .wb_i   (mem_wb_i),
    .hit_o  (mem_hit)
  );

  pcw_mult_chk #(.REG_W(REG_W), .ADJ_W(ADJ_W)) mult_chk_i (
    .list_i (reg_list_i),
    .base_i (mem_base_i),
    .load_i (mem_load_i),
    .adj_i  (mult_adj_i),
    .hit_o  (mult_hit)
  );

  always_comb begin
    may_write_pc_o = 1'b0;
    unsup_o        = 1'b0;
    case (cls_i)
      CLS_ALU:  may_write_pc_o = alu_hit;
      CLS_MEM:  may_write_pc_o = mem_hit;
      CLS_MULT: may_write_pc_o = mult_hit;
      CLS_BIMM,
      CLS_BREG: may_write_pc_o = 1'b1;
      default:  unsup_o        = 1'b1;
    endcase
    // R8: the flag and the unsupported indication never coexist
    p_unsup_excl_r8: assert (!(unsup_o && may_write_pc_o));
    // R7: branch classes are never unsupported and always flagged
    p_branch_r7: assert (!(cls_i == CLS_BIMM || cls_i == CLS_BREG) || (may_write_pc_o && !unsup_o));
  end
endmodule

// File: tb/pcw_classifier_tb.sv
module pcw_classifier_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cls;
  logic [3:0] dst, tgt, base;
  logic       ld, dual, wb;
  logic [15:0] list;
  logic [7:0] adj;
  logic       flag, unsup;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcw_classifier dut_i (
    .cls_i(cls), .alu_dst_i(dst), .mem_tgt_i(tgt), .mem_base_i(base),
    .mem_load_i(ld), .mem_dual_i(dual), .mem_wb_i(wb), .reg_list_i(list),
    .mult_adj_i(adj), .may_write_pc_o(flag), .unsup_o(unsup)
  );

  // Behavioural model written from the requirements.
  function automatic bit model_flag();
    int t;
    t = tgt;
    if (cls == 3 || cls == 4) return 1;
    if (cls == 0) return dst == 15;
    if (cls == 1) begin
      if (wb && base == 15) return 1;
      if (!ld) return 0;
      if (t == 15) return 1;
      if (dual && t + 1 == 15) return 1;
      return 0;
    end
    if (cls == 2) begin
      if (adj != 0 && base == 15) return 1;
      return ld && list[15];
    end
    return 0;
  endfunction

  task automatic apply(input string tag, input logic [2:0] c, input logic [3:0] d,
                       input logic [3:0] t, input logic [3:0] b, input logic l,
                       input logic du, input logic w, input logic [15:0] li,
                       input logic [7:0] a, input int exp_flag);
    bit ef, eu;
    @(posedge clk);
    cls = c; dst = d; tgt = t; base = b; ld = l; dual = du; wb = w; list = li; adj = a;
    @(negedge clk);
    ef = model_flag();
    eu = (c > 4);
    if (exp_flag >= 0 && ef != exp_flag[0]) begin
      $display("bench model disagrees with plan for %s", tag);
    end
    total++;
    if (flag !== ef) begin
      bad++;
      $display("FAIL %s flag actual=%b expected=%b", tag, flag, ef);
    end
    total++;
    if (unsup !== eu) begin
      bad++;
      $display("FAIL %s unsup actual=%b expected=%b", tag, unsup, eu);
    end
  endtask

  initial begin
    cls = 0; dst = 0; tgt = 0; base = 0; ld = 0; dual = 0; wb = 0; list = 0; adj = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset/idle state: ALU to r0
    @(negedge clk);
    total++;
    if (flag !== 1'b0 || unsup !== 1'b0) begin
      bad++;
      $display("FAIL R9 idle actual=%b%b expected=00", flag, unsup);
    end
    apply("R1 alu dst15", 0, 15, 0, 0, 0, 0, 0, 16'h0, 0, 1);
    apply("R1 alu dst14", 0, 14, 15, 15, 1, 0, 0, 16'h8000, 0, 0);
    apply("R2 load t15", 1, 0, 15, 3, 1, 0, 0, 0, 0, 1);
    apply("R2 store t15", 1, 0, 15, 3, 0, 0, 0, 0, 0, 0);
    apply("R3 dual t14", 1, 0, 14, 2, 1, 1, 0, 0, 0, 1);
    apply("R3 dual t15", 1, 0, 15, 2, 1, 1, 0, 0, 0, 1);
    apply("R3 dual t13", 1, 0, 13, 2, 1, 1, 0, 0, 0, 0);
    apply("R3 single t14", 1, 0, 14, 2, 1, 0, 0, 0, 0, 0);
    apply("R4 ldm bit15", 2, 0, 0, 4, 1, 0, 0, 16'h8001, 0, 1);
    apply("R4 stm bit15", 2, 0, 0, 4, 0, 0, 0, 16'h8001, 0, 0);
    apply("R4 ldm no15", 2, 0, 0, 4, 1, 0, 0, 16'h7fff, 0, 0);
    apply("R5 store wb b15", 1, 0, 1, 15, 0, 0, 1, 0, 0, 1);
    apply("R5 load wb b15", 1, 0, 1, 15, 1, 0, 1, 0, 0, 1);
    apply("R5 nowb b15", 1, 0, 1, 15, 1, 0, 0, 0, 0, 0);
    apply("R6 adj pos b15", 2, 0, 0, 15, 0, 0, 0, 16'h0003, 8'd8, 1);
    apply("R6 adj neg b15", 2, 0, 0, 15, 0, 0, 0, 16'h0003, 8'hf8, 1);
    apply("R6 adj zero b15", 2, 0, 0, 15, 0, 0, 1, 16'h0003, 8'd0, 0);
    apply("R6 adj b14", 2, 0, 0, 14, 0, 0, 0, 16'h0003, 8'd4, 0);
    apply("R7 bimm", 3, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    apply("R7 breg", 4, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    apply("R8 cls5", 5, 15, 15, 15, 1, 1, 1, 16'hffff, 8'd1, 0);
    apply("R8 cls6", 6, 15, 15, 15, 1, 1, 1, 16'hffff, 8'd1, 0);
    apply("R8 cls7", 7, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] rt, rb;
      rt = ($urandom % 3 == 0) ? 4'(14 + $urandom % 2) : 4'($urandom);
      rb = ($urandom % 3 == 0) ? 4'd15 : 4'($urandom);
      apply("R9 random", 3'($urandom), rt, rt, rb, 1'($urandom), 1'($urandom),
            1'($urandom), 16'($urandom), ($urandom % 2 == 0) ? 8'd0 : 8'($urandom), -1);
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule